// File: doc/BRIEF.md
# LCD Segment Frame Buffer

This block keeps the pixel data for a multiplexed segment display. It holds one entry per common (COM) line, up to eight of them, and moves that data into the latches that feed the display driver. Software fills the buffer through a simple word-wide register port. Each COM entry is seen as two 32-bit words: a low word for segments 31..0 and a high word for the segments above 31.

Once the buffer is filled, software sets an update request. At the next frame boundary, the whole buffer is copied into the output latches in one cycle. At that point the request clears and a done flag sets. While a request is pending, the buffer is locked, so a half-written image can never reach the display. Software polls the request flag and waits for it to clear before it writes again.

The duty input selects how many COM lines are active. In eight-COM mode the four top segment lines serve as COM lines, so those four segment bits are forced to zero in the latched image.

Top module: `lcd_frame_buffer`

## Requirements
- R1: While `rst_n` is low, or for a cycle in which `en_i` is low, every buffer entry, every latched output bit, the request flag and the done flag become zero.
- R2: A register address with bit 4 clear selects a buffer word. Address bits 3..1 give the COM index, and address bit 0 selects the high word (1) or the low word (0). A read returns the stored bits. High-word bits at and above position SEG_BITS-32 are not stored and read as zero.
- R3: The control word is at address 16. Writing it with data bit 0 set raises the request flag. Reading it returns the request flag in bit 0, the done flag in bit 1, and zero in all other bits.
- R4: A transfer happens at the first clock edge where `frame_tick_i` is high and a request is already registered. A request written in the same cycle as a tick waits for a later tick. On the transfer edge the request clears, the done flag sets, and the new image appears on `disp_seg_o`.
- R5: Buffer writes are ignored while a request is pending, and reads in that period return the buffered contents.
- R6: Writing the control word with data bit 1 set clears the done flag. If a transfer happens on the same edge, the done flag stays set.
- R7: The duty code sets the active COM count: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 8, and any other code gives 1. A buffer write to a COM index at or above the active count is ignored.
- R8: On a transfer, the latched vector of each COM index at or above the active count becomes zero.
- R9: On a transfer with duty code 4, segment bits SEG_BITS-1 down to SEG_BITS-4 are latched as zero. With any other code, all SEG_BITS bits are latched as stored.
- R10: Between transfers the latched outputs hold. A frame tick with no pending request, and any buffer write, leaves `disp_seg_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; when low, clears buffer, latches and flags |
| duty_i | input | 3 | Active COM count code |
| frame_tick_i | input | 1 | One-cycle frame-boundary strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| disp_seg_o | output | 8*SEG_BITS | Latched segment vectors; COM c is at bits [c*SEG_BITS +: SEG_BITS] |

## Verification
The in-line properties watch the handshake on every cycle:
- a request rises only after a control write;
- done rises only on a transfer, and a transfer clears the request;
- buffer entries stay stable while locked or when the target COM is inactive;
- the latches move only on a transfer;
- inactive COMs and the four masked top segments come out as zero.

Only the bench's sweeps can show that the right data reaches the right COM and word under each duty code. They also show that a request and a tick in the same cycle defer the copy, and that a set of the done flag wins over a clear on the same edge.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  localparam int NUM_COM = 8;
  localparam int COM_AW  = 3;

  typedef enum logic [2:0] {
    DUTY_1 = 3'd0,
    DUTY_2 = 3'd1,
    DUTY_3 = 3'd2,
    DUTY_4 = 3'd3,
    DUTY_8 = 3'd4
  } duty_e;

  function automatic logic [3:0] com_count(input logic [2:0] code);
    case (code)
      DUTY_2:  com_count = 4'd2;
      DUTY_3:  com_count = 4'd3;
      DUTY_4:  com_count = 4'd4;
      DUTY_8:  com_count = 4'd8;
      default: com_count = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/lcdb_ram.sv
module lcdb_ram
  import lcdb_pkg::*;
#(
  parameter int SEG_BITS = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic                        lock_i,
  input  logic                        we_i,
  input  logic [COM_AW-1:0]           com_i,
  input  logic                        hi_i,
  input  logic [31:0]                 wdata_i,
  input  logic [3:0]                  act_cnt_i,
  output logic [31:0]                 rdata_o,
  output logic [NUM_COM*SEG_BITS-1:0] mem_flat_o
);
  localparam int HI_BITS = SEG_BITS - 32;

  logic [SEG_BITS-1:0] mem_q [NUM_COM];
  logic                wr_ok;

  assign wr_ok = we_i && !lock_i && ({1'b0, com_i} < act_cnt_i);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[c] <= '0;
      end else if (!en_i) begin
        mem_q[c] <= '0;
      end else if (wr_ok && (com_i == COM_AW'(c))) begin
        if (hi_i) mem_q[c][SEG_BITS-1:32] <= wdata_i[HI_BITS-1:0];
        else      mem_q[c][31:0]          <= wdata_i;
      end
    end
    assign mem_flat_o[c*SEG_BITS +: SEG_BITS] = mem_q[c];

    AST_RAM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && lock_i) |=> $stable(mem_q[c])); // R5
    AST_INACTIVE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && we_i && com_i == COM_AW'(c) && ({1'b0, com_i} >= act_cnt_i))
        |=> $stable(mem_q[c])); // R7
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (mem_q[c] == '0)); // R1
  end

  logic [SEG_BITS-1:0] rsel;
  logic [63:0]         rext;
  assign rsel    = mem_q[com_i];
  assign rext    = 64'(rsel);
  assign rdata_o = hi_i ? rext[63:32] : rext[31:0];
endmodule

// File: rtl/lcdb_update_ctl.sv
module lcdb_update_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic frame_tick_i,
  input  logic req_set_i,
  input  logic done_clr_i,
  output logic req_o,
  output logic done_o,
  output logic xfer_o
);
  logic req_q, done_q;

  assign xfer_o = en_i && req_q && frame_tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q <= (req_q && !xfer_o) || req_set_i;
      if (xfer_o)          done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;

  AST_XFER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && !req_set_i) |=> (!req_o && done_o)); // R4
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(xfer_o)); // R4
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(req_set_i)); // R3
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && done_o && done_clr_i && !xfer_o) |=> !done_o); // R6
endmodule

// File: rtl/lcdb_latch.sv
module lcdb_latch
  import lcdb_pkg::*;
#(
  parameter int SEG_BITS = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic                        xfer_i,
  input  logic [2:0]                  duty_i,
  input  logic [3:0]                  act_cnt_i,
  input  logic [NUM_COM*SEG_BITS-1:0] mem_flat_i,
  output logic [NUM_COM*SEG_BITS-1:0] disp_flat_o
);
  localparam int MUX_SEGS = 4;

  logic [SEG_BITS-1:0] seg_mask;
  always_comb begin
    seg_mask = '1;
    if (duty_i == DUTY_8) seg_mask[SEG_BITS-1 -: MUX_SEGS] = '0;
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic [SEG_BITS-1:0] disp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        disp_q <= '0;
      end else if (!en_i) begin
        disp_q <= '0;
      end else if (xfer_i) begin
        if (4'(c) < act_cnt_i) disp_q <= mem_flat_i[c*SEG_BITS +: SEG_BITS] & seg_mask;
        else                   disp_q <= '0;
      end
    end
    assign disp_flat_o[c*SEG_BITS +: SEG_BITS] = disp_q;

    AST_INACTIVE_COM_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && xfer_i && (4'(c) >= act_cnt_i)) |=> (disp_q == '0)); // R8
    AST_TOP_SEGS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && xfer_i && duty_i == DUTY_8) |=> (disp_q[SEG_BITS-1 -: MUX_SEGS] == '0)); // R9
  end

  AST_HOLD_BETWEEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !xfer_i) |=> $stable(disp_flat_o)); // R10
endmodule

// File: rtl/lcd_frame_buffer.sv
module lcd_frame_buffer
  import lcdb_pkg::*;
#(
  parameter int SEG_BITS = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic [2:0]                  duty_i,
  input  logic                        frame_tick_i,
  input  logic                        reg_we_i,
  input  logic [4:0]                  reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  output logic [NUM_COM*SEG_BITS-1:0] disp_seg_o
);
  localparam logic [4:0] CTL_ADDR = 5'd16;

  logic                        sel_ram, sel_ctl;
  logic                        req, done, xfer;
  logic [3:0]                  act_cnt;
  logic [31:0]                 ram_rdata;
  logic [NUM_COM*SEG_BITS-1:0] mem_flat;

  assign sel_ram = !reg_addr_i[4];
  assign sel_ctl = (reg_addr_i == CTL_ADDR);
  assign act_cnt = com_count(duty_i);

  lcdb_ram #(.SEG_BITS(SEG_BITS)) u_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .lock_i     (req),
    .we_i       (reg_we_i && sel_ram),
    .com_i      (reg_addr_i[3:1]),
    .hi_i       (reg_addr_i[0]),
    .wdata_i    (reg_wdata_i),
    .act_cnt_i  (act_cnt),
    .rdata_o    (ram_rdata),
    .mem_flat_o (mem_flat)
  );

  lcdb_update_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .frame_tick_i (frame_tick_i),
    .req_set_i    (reg_we_i && sel_ctl && reg_wdata_i[0]),
    .done_clr_i   (reg_we_i && sel_ctl && reg_wdata_i[1]),
    .req_o        (req),
    .done_o       (done),
    .xfer_o       (xfer)
  );

  lcdb_latch #(.SEG_BITS(SEG_BITS)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .xfer_i      (xfer),
    .duty_i      (duty_i),
    .act_cnt_i   (act_cnt),
    .mem_flat_i  (mem_flat),
    .disp_flat_o (disp_seg_o)
  );

  always_comb begin
    if (sel_ram)      reg_rdata_o = ram_rdata;
    else if (sel_ctl) reg_rdata_o = {30'd0, done, req};
    else              reg_rdata_o = '0;
  end
endmodule

// File: tb/lcd_frame_buffer_tb_top.sv
module lcd_frame_buffer_tb_top;
  localparam int SEG  = 52;
  localparam int NCOM = 8;
  localparam logic [63:0] FULL_M = (64'd1 << SEG) - 1;
  localparam logic [63:0] MUX_M  = (64'd1 << (SEG - 4)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0, we = 1'b0;
  logic [2:0]  duty = 3'd0;
  logic [4:0]  addr = 5'd0;
  logic [31:0] wdata = 32'd0, rdata;
  logic [NCOM*SEG-1:0] disp;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_ram  [NCOM];
  logic [63:0] m_disp [NCOM];

  always #4 clk = ~clk;

  lcd_frame_buffer #(.SEG_BITS(SEG)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .duty_i(duty), .frame_tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .disp_seg_o(disp)
  );

  function automatic int cnt_of(input int d);
    case (d) 1: return 2; 2: return 3; 3: return 4; 4: return 8; default: return 1; endcase
  endfunction

  function automatic logic [31:0] pat(input int c, input int h, input int d);
    return 32'hA5C3_0F96 ^ (32'(c) * 32'h0101_0101) ^ (32'(h) * 32'h8421_8421) ^ (32'(d) * 32'h1357_9BDF);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a; #1; d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic model_xfer(input int d);
    for (int c = 0; c < NCOM; c++)
      m_disp[c] = (c < cnt_of(d)) ? (m_ram[c] & ((d == 4) ? MUX_M : FULL_M)) : 64'd0;
  endtask

  task automatic check_disp(input string req);
    for (int c = 0; c < NCOM; c++) check(req, 64'(disp[c*SEG +: SEG]), m_disp[c]);
  endtask

  task automatic check_ram(input string req);
    logic [31:0] v;
    for (int c = 0; c < NCOM; c++) begin
      rd(5'(c*2), v);     check(req, 64'(v), m_ram[c][31:0]);
      rd(5'(c*2 + 1), v); check(req, 64'(v), (m_ram[c] & FULL_M) >> 32);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCOM; c++) begin m_ram[c] = 0; m_disp[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1; en = 1'b1;
    // R1 reset state
    check_disp("R1");
    check_ram("R1");
    rd(5'd16, v); check("R1", 64'(v), 64'd0);

    for (int d = 0; d < 6; d++) begin
      duty = 3'(d);
      for (int c = 0; c < NCOM; c++)
        for (int h = 0; h < 2; h++) begin
          wr(5'(c*2 + h), pat(c, h, d));
          if (c < cnt_of(d)) begin          // R7 writes beyond active count dropped
            if (h == 1) m_ram[c][63:32] = pat(c, h, d);
            else        m_ram[c][31:0]  = pat(c, h, d);
          end
        end
      check_ram("R2_R7");
      pulse_tick();
      check_disp("R10");                     // tick with nothing pending
      wr(5'd16, 32'd1);
      rd(5'd16, v); check("R3", 64'(v), 64'd1);
      wr(5'd0, ~pat(0, 0, d));               // R5 locked
      wr(5'd1, ~pat(0, 1, d));
      check_ram("R5");
      check_disp("R10");
      pulse_tick();
      model_xfer(d);
      rd(5'd16, v); check("R4", 64'(v), 64'd2);
      check_disp(d == 4 ? "R9" : "R4_R8");
      wr(5'd16, 32'd2);
      rd(5'd16, v); check("R6", 64'(v), 64'd0);
    end

    // R4: request and tick in the same cycle does not transfer
    duty = 3'd3;
    wr(5'd2, 32'h1234_5678); m_ram[1][31:0] = 32'h1234_5678;
    @(negedge clk); we = 1'b1; addr = 5'd16; wdata = 32'd1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(5'd16, v); check("R4", 64'(v), 64'd1);
    check_disp("R4");
    // R6: transfer and done clear on the same edge, set wins
    @(negedge clk); we = 1'b1; addr = 5'd16; wdata = 32'd2; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    model_xfer(3);
    rd(5'd16, v); check("R6", 64'(v), 64'd2);
    check_disp("R4");

    // R1: enable low clears everything
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    for (int c = 0; c < NCOM; c++) begin m_ram[c] = 0; m_disp[c] = 0; end
    check_disp("R1");
    check_ram("R1");
    rd(5'd16, v); check("R1", 64'(v), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule